// File: doc/BRIEF.md
# Majority-Vote Input Deglitch Filter

This block cleans up a noisy single-bit signal that is already synchronous to the local clock. It keeps a sliding window of the last `WIN_LEN` accepted samples and a running count of the ones in that window. A registered output is set or cleared from that count. The output turns high once at least `HI_THR` of the windowed samples are ones. It turns low once at most `WIN_LEN - HI_THR` of them are ones. Between those two limits the output keeps its value, which gives a hysteresis band.

A strict filter only changes its output when every tap agrees, so one stray sample can hold off the change for a whole window. A vote accepts a level that is mostly present. A single flipped sample therefore no longer blocks recognition of a stable level. Setting `HI_THR` equal to `WIN_LEN` gives back the strict all-agree behaviour. A 3-sample window with a threshold of 2 gives a 2-of-3 vote. The default is an 8-sample window with a threshold of 6.

The sample enable sets the sampling rate. The window moves, the count is updated and the vote is taken only on cycles where the enable is high. The decision logic is a two-state machine: `ST_LOW` and `ST_HIGH`. Transition `T_RISE` goes from `ST_LOW` to `ST_HIGH` when an enabled sample leaves the count at or above `HI_THR`. Transition `T_FALL` goes from `ST_HIGH` to `ST_LOW` when an enabled sample leaves the count at or below `WIN_LEN - HI_THR`. In every other case each state holds itself: `T_HOLD_LOW` and `T_HOLD_HIGH`.

Top module: `maj_deglitch`

## Requirements
- R1: A synchronous reset empties the window, setting every tap to 0, and drives `dout` to 0. After reset, `dout` can only rise once `HI_THR` enabled samples of value 1 are in the window.
- R2: On a cycle where `smp_en` is 0, nothing moves: the window, the count and `dout` are all unchanged, whatever `din` is.
- R3: On an enabled cycle, the window takes in `din` and drops its oldest sample. If the ones count of the updated window is at least `HI_THR`, `dout` is 1 right after that same clock edge.
- R4: On an enabled cycle, if the ones count of the updated window is at most `WIN_LEN - HI_THR`, `dout` is 0 right after that same clock edge.
- R5: On an enabled cycle, if the ones count lies strictly between the two thresholds, `dout` keeps its previous value.
- R6: With the default setting of 8 samples and a threshold of 6, starting from an empty window, the enabled samples 1,1,1,0,1,1,1 turn `dout` to 1 on the seventh sample, even though one glitch lies inside the window.
- R7: With `HI_THR` equal to `WIN_LEN`, the filter acts as the strict all-agree filter. With `WIN_LEN`=3 and `HI_THR`=2, it acts as a 2-of-3 vote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample enable; the window shifts only when this is high |
| din | input | 1 | Raw input, already synchronous to `clk` |
| dout | output | 1 | Filtered output, driven from a register |

## Verification
Each enabled sample changes `dout` at the same rising edge that captures it, because one register lies between `din` and `dout`. An idle cycle must leave `dout` exactly as it was at that edge. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares the output 5 ns after that edge against a model that applies the same sample to its own copy of the window. A fixed-seed random noisy stream is used on three parameter settings: 8 samples with threshold 6, the 2-of-3 vote, and a strict 4-of-4. Directed runs cover the reset state and the single-glitch case.

// File: rtl/dg_pkg.sv
package dg_pkg;
    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } dg_state_e;
endpackage

// File: rtl/dg_window.sv
module dg_window #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [DEPTH-1:0] taps,
    output logic             bit_out
);
    // Newest sample enters at bit 0; the oldest one sits at the top bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (shift_en) begin
            taps <= {taps[DEPTH-2:0], bit_in};
        end
    end

    assign bit_out = taps[DEPTH-1];

    p_idle_window_r2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(taps));
endmodule

// File: rtl/dg_tally.sv
module dg_tally #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_en,
    input  logic          bit_add,
    input  logic          bit_drop,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nx
);
    localparam logic [CW-1:0] MAX_C = CW'(DEPTH);

    // Running total: add the entering bit and remove the leaving bit.
    always_comb begin
        cnt_nx = cnt_q + CW'(bit_add) - CW'(bit_drop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (upd_en) begin
            cnt_q <= cnt_nx;
        end
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= MAX_C);
endmodule

// File: rtl/dg_vote_fsm.sv
module dg_vote_fsm
    import dg_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int HI_THR = 6,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vote_en,
    input  logic [CW-1:0] cnt_nx,
    output logic          level
);
    localparam int LO_THR = DEPTH - HI_THR;
    localparam logic [CW-1:0] HI_C = CW'(HI_THR);
    localparam logic [CW-1:0] LO_C = CW'(LO_THR);

    dg_state_e state_q;
    dg_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                if (vote_en && (cnt_nx >= HI_C)) begin
                    state_d = ST_HIGH;   // T_RISE
                end
            end
            ST_HIGH: begin
                if (vote_en && (cnt_nx <= LO_C)) begin
                    state_d = ST_LOW;    // T_FALL
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        level = (state_q == ST_HIGH);
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !vote_en |=> $stable(level));

    p_rise_thr_r3: assert property (@(posedge clk) disable iff (rst)
        vote_en && (cnt_nx >= HI_C) |=> level);

    p_fall_thr_r4: assert property (@(posedge clk) disable iff (rst)
        vote_en && (cnt_nx <= LO_C) |=> !level);

    p_band_hold_r5: assert property (@(posedge clk) disable iff (rst)
        vote_en && (cnt_nx > LO_C) && (cnt_nx < HI_C) |=> $stable(level));
endmodule

// File: rtl/maj_deglitch.sv
module maj_deglitch #(
    parameter int WIN_LEN = 8,
    parameter int HI_THR  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_en,
    input  logic din,
    output logic dout
);
    localparam int CW     = $clog2(WIN_LEN + 1);
    localparam int LO_THR = WIN_LEN - HI_THR;

    logic [WIN_LEN-1:0] taps;
    logic               leaving;
    logic [CW-1:0]      cnt_q;
    logic [CW-1:0]      cnt_nx;

    initial begin
        p_param_sane_r5: assert ((2 * HI_THR > WIN_LEN) && (HI_THR <= WIN_LEN)
                                 && (LO_THR >= 0) && (WIN_LEN >= 2));
    end

    dg_window #(.DEPTH(WIN_LEN)) u_window (
        .clk      (clk),
        .rst      (rst),
        .shift_en (smp_en),
        .bit_in   (din),
        .taps     (taps),
        .bit_out  (leaving)
    );

    dg_tally #(.DEPTH(WIN_LEN), .CW(CW)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (smp_en),
        .bit_add  (din),
        .bit_drop (leaving),
        .cnt_q    (cnt_q),
        .cnt_nx   (cnt_nx)
    );

    dg_vote_fsm #(.DEPTH(WIN_LEN), .HI_THR(HI_THR), .CW(CW)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .vote_en (smp_en),
        .cnt_nx  (cnt_nx),
        .level   (dout)
    );

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!dout && (cnt_q == '0) && (taps == '0)));

    p_cnt_track_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q == CW'($countones(taps)));
endmodule

// File: tb/maj_deglitch_bench.sv
`timescale 1ns/1ps
module maj_deglitch_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_en = 1'b0;
    logic din = 1'b0;
    logic dout8, dout3, dout4;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] w8 = '0;
    logic [2:0] w3 = '0;
    logic [3:0] w4 = '0;
    logic e8 = 1'b0, e3 = 1'b0, e4 = 1'b0;

    always #10 clk = ~clk;

    maj_deglitch u_maj_deglitch (
        .clk(clk), .rst(rst), .smp_en(smp_en), .din(din), .dout(dout8));
    maj_deglitch #(.WIN_LEN(3), .HI_THR(2)) u_vote3 (
        .clk(clk), .rst(rst), .smp_en(smp_en), .din(din), .dout(dout3));
    maj_deglitch #(.WIN_LEN(4), .HI_THR(4)) u_strict4 (
        .clk(clk), .rst(rst), .smp_en(smp_en), .din(din), .dout(dout4));

    function automatic logic vote(int ones, int n, int k, logic prev);
        if (ones >= k) return 1'b1;
        if (ones <= n - k) return 1'b0;
        return prev;
    endfunction

    function automatic string tag_of(logic en, logic prev, logic nxt);
        if (!en) return "R2";
        if (nxt && !prev) return "R3";
        if (!nxt && prev) return "R4";
        return "R5";
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_en = 1'b1;
        din = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        w8 = '0; w3 = '0; w4 = '0;
        e8 = 1'b0; e3 = 1'b0; e4 = 1'b0;
        chk(dout8, 1'b0, "R1", "reset 8/6");
        chk(dout3, 1'b0, "R1", "reset 2/3");
        chk(dout4, 1'b0, "R1", "reset 4/4");
        @(negedge clk);
        rst = 1'b0;
        smp_en = 1'b0;
    endtask

    task automatic step(input logic d, input logic e);
        logic p8, p3;
        @(negedge clk);
        din = d;
        smp_en = e;
        @(posedge clk);
        #5;
        p8 = e8;
        p3 = e3;
        if (e) begin
            w8 = {w8[6:0], d};
            w3 = {w3[1:0], d};
            w4 = {w4[2:0], d};
            e8 = vote($countones(w8), 8, 6, e8);
            e3 = vote($countones(w3), 3, 2, e3);
            e4 = vote($countones(w4), 4, 4, e4);
        end
        chk(dout8, e8, tag_of(e, p8, e8), "8/6");
        chk(dout3, e3, tag_of(e, p3, e3), "2/3");
        chk(dout4, e4, "R7", "strict 4/4");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic lvl;
        void'($urandom(32'd20240611));
        do_reset();

        // R6: a single glitch inside a mostly high window
        step(1, 1); step(1, 1); step(1, 1); step(0, 1);
        step(1, 1); step(1, 1); step(1, 1);
        chk(dout8, 1'b1, "R6", "glitch tolerated 8/6");
        chk(dout4, 1'b0, "R7", "strict filter blocked by glitch");
        chk(dout3, 1'b1, "R7", "2-of-3 vote high");

        // R2: idle cycles with a toggling input change nothing
        for (int i = 0; i < 6; i++) step(i[0], 0);
        chk(dout8, 1'b1, "R2", "held while idle");

        // R4 / R5: falling through the band
        step(0, 1); step(0, 1);
        chk(dout8, 1'b1, "R5", "inside band holds");
        step(0, 1); step(0, 1); step(1, 1); step(0, 1);
        step(0, 1); step(0, 1);
        chk(dout8, 1'b0, "R4", "low after mostly zeros");

        // R1: ones present before reset do not survive it
        for (int i = 0; i < 8; i++) step(1, 1);
        do_reset();
        for (int i = 0; i < 5; i++) step(1, 1);
        chk(dout8, 1'b0, "R1", "five ones after reset stay low");
        step(1, 1);
        chk(dout8, 1'b1, "R1", "sixth one after reset rises");

        // Random noisy stream with occasional level changes
        lvl = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 40) == 0) lvl = ~lvl;
            step((($urandom % 10) == 0) ? ~lvl : lvl, ($urandom % 4) != 0);
            if (i == 2000) do_reset();
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule